// File: doc/BRIEF.md
# Two-Wire Serial Memory Target

This block is a synthesizable target-side model of a 512-byte serial memory on a two-wire open-drain bus. A fast system clock samples SCL and SDA through a short synchronizer. The block recognises start and stop conditions and shifts in bytes on SCL rising edges. It drives SDA low only through a pull-low output, and it changes that output only after SCL falling edges. Two strap inputs give the block its bus identity. One bit of the header byte selects the upper half of the array.

A write transaction carries a header, one word-address byte and up to sixteen data bytes. The data bytes go into a page buffer. A stop moves the buffered bytes into the array during an internal busy period whose length is a parameter, and the target answers nothing while that period runs. A read transaction streams bytes from an internal address counter for as long as the master acknowledges. A random read is built from a header-only write that loads the counter, followed by a repeated start. A write-protect input cancels programming.

The controller is a single state machine with these states:
- S_IDLE: waits for a start.
- S_DEV: receives the header.
- S_DEV_ACK: acknowledge slot for the header.
- S_WORD: receives the word address.
- S_WORD_ACK: acknowledge slot for the word address.
- S_WDATA: receives a data byte.
- S_WDATA_ACK: acknowledge slot for a data byte.
- S_RDATA: shifts a byte out.
- S_RACK: samples the master's acknowledge.

Transitions:
- A start moves any state to S_DEV, and a stop moves any state to S_IDLE.
- On the SCL falling edge after the eighth bit, S_DEV goes to S_DEV_ACK on a match and to S_IDLE otherwise.
- On the SCL falling edge after the eighth bit, S_WORD goes to S_WORD_ACK, S_WDATA goes to S_WDATA_ACK, and S_RDATA goes to S_RACK.
- On the falling edge that ends an acknowledge slot, S_DEV_ACK goes to S_RDATA for a read and to S_WORD for a write.
- On the falling edge that ends an acknowledge slot, S_WORD_ACK and S_WDATA_ACK both go to S_WDATA.
- On the falling edge that ends an acknowledge slot, S_RACK goes to S_RDATA after a master acknowledge and to S_IDLE after a master NACK.

Top module: `serial_mem_target`

## Requirements
- R1: After reset the target releases SDA, every array byte reads 8'hFF and the address counter is 0.
- R2: A start (SDA falling while SCL is high) begins header reception from any state. A stop (SDA rising while SCL is high) returns the target to idle with SDA released.
- R3: The header is sent MSB first. Bits 7:4 must be 4'b1010, bit 3 must equal strap_hi_i, bit 2 must equal strap_lo_i, bit 1 is array address bit 8 (the block bit) and bit 0 selects read (1) or write (0). On a match the target pulls SDA low during the ninth clock.
- R4: On a header mismatch the target does not acknowledge, and it ignores all bus activity until the next start. Bytes sent after the mismatch change no array content.
- R5: In a write, the word-address byte and every data byte are acknowledged. The word byte and the block bit load the counter as {block, word}. Each data byte is stored at the counter, and then only the low 4 counter bits increment, wrapping inside the same 16-byte page.
- R6: A stop that follows at least one data byte starts a busy period of BUSY_CYCLES system clocks, during which the buffered bytes are written into the array. A stop with no data byte starts no busy period.
- R7: While busy, the target acknowledges nothing, including a matching header. After the busy period it acknowledges again.
- R8: If wp_i is high at the stop, the array is unchanged and no busy period starts. Header, word and data bytes are still acknowledged.
- R9: A read header with no word address returns the byte at the counter and ignores the header's block bit. The counter then holds the last accessed address plus one.
- R10: A write header with a word address, followed by a repeated start and a read header, returns the byte at that address.
- R11: Read data is sent MSB first. Each byte the master acknowledges is followed by the byte at the next address, and address 511 is followed by address 0. A master NACK ends the read with SDA released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | High to pull the data line low |
| strap_hi_i | input | 1 | Strap compared with header bit 3 |
| strap_lo_i | input | 1 | Strap compared with header bit 2 |
| wp_i | input | 1 | High blocks all programming |

## Verification
A wrong controller state shows up at the ports within one byte time. It appears as a missing or extra acknowledge in the ninth clock, or as SDA held low when the master expects the line to be free. A wrong address counter or page wrap stays hidden until a later read returns a byte from the wrong location. For that reason every write is followed by random, current and sequential reads that cross the page and array boundaries. The busy logic is checked at the ports by probing with a header right after a stop and again after the busy period ends.

// File: rtl/smt_pkg.sv
package smt_pkg;
    localparam int          MEM_ADDR_W = 9;
    localparam int          BYTE_W     = 8;
    localparam logic [3:0]  DEV_TYPE   = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WORD,
        S_WORD_ACK,
        S_WDATA,
        S_WDATA_ACK,
        S_RDATA,
        S_RACK
    } smt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } smt_bus_ev_t;
endpackage

// File: rtl/smt_line_sync.sv
module smt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output smt_pkg::smt_bus_ev_t ev
);
    // Pipes idle high, like a pulled-up bus.
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now = scl_pipe[STAGES-1];
    assign scl_old = scl_pipe[STAGES];
    assign sda_now = sda_pipe[STAGES-1];
    assign sda_old = sda_pipe[STAGES];

    always_comb begin
        ev.scl_rise = scl_now & ~scl_old;
        ev.scl_fall = ~scl_now & scl_old;
        ev.start    = scl_now & scl_old & sda_old & ~sda_now;
        ev.stop     = scl_now & scl_old & ~sda_old & sda_now;
        ev.sda      = sda_now;
    end
endmodule

// File: rtl/smt_busy_timer.sv
module smt_busy_timer #(
    parameter int BUSY_CYCLES = 2000,
    parameter int PAGE_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    output logic              busy,
    output logic              commit_en,
    output logic [PAGE_W-1:0] commit_idx
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int LEN = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;
    localparam int CW  = $clog2(LEN + 1);

    logic [CW-1:0] cnt;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q <= 1'b1;
                cnt    <= '0;
            end
        end else if (cnt == CW'(LEN - 1)) begin
            busy_q <= 1'b0;
            cnt    <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign busy       = busy_q;
    assign commit_en  = busy_q && (cnt < CW'(PAGE_BYTES));
    assign commit_idx = cnt[PAGE_W-1:0];

    assert_busy_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy_q) |=> busy_q);
    assert_busy_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt < CW'(LEN)));
endmodule

// File: rtl/smt_store.sv
module smt_store #(
    parameter int PAGE_W = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [smt_pkg::MEM_ADDR_W-1:0]         rd_addr,
    output logic [smt_pkg::BYTE_W-1:0]             rd_data,
    input  logic                                   buf_we,
    input  logic [PAGE_W-1:0]                      buf_idx,
    input  logic [smt_pkg::BYTE_W-1:0]             buf_data,
    input  logic                                   buf_clr,
    output logic                                   has_data,
    input  logic                                   arm,
    input  logic [smt_pkg::MEM_ADDR_W-PAGE_W-1:0]  arm_page,
    input  logic                                   commit_en,
    input  logic [PAGE_W-1:0]                      commit_idx
);
    localparam int AW         = smt_pkg::MEM_ADDR_W;
    localparam int DW         = smt_pkg::BYTE_W;
    localparam int DEPTH      = 1 << AW;
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int PG_W       = AW - PAGE_W;

    logic [DW-1:0]         mem  [DEPTH];
    logic [DW-1:0]         pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask, cmask;
    logic [PG_W-1:0]       cpage;

    assign rd_data  = mem[rd_addr];
    assign has_data = |pmask;

    always_ff @(posedge clk) begin
        if (buf_we) pbuf[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pmask <= '0;
            cmask <= '0;
            cpage <= '0;
        end else begin
            if (arm) begin
                cmask <= pmask;
                cpage <= arm_page;
            end
            if (arm || buf_clr) pmask <= '0;
            else if (buf_we)    pmask[buf_idx] <= 1'b1;
        end
    end

    // One byte per clock moves into the array during the busy period.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (commit_en && cmask[commit_idx]) begin
            mem[{cpage, commit_idx}] <= pbuf[commit_idx];
        end
    end

    assert_no_fill_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |-> !buf_we);
endmodule

// File: rtl/serial_mem_target.sv
module serial_mem_target #(
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    input  logic strap_hi_i,
    input  logic strap_lo_i,
    input  logic wp_i
);
    import smt_pkg::*;

    localparam int AW   = MEM_ADDR_W;
    localparam int DW   = BYTE_W;
    localparam int PG_W = AW - PAGE_W;

    smt_bus_ev_t   ev;
    smt_state_e    state_q, state_d;
    logic [3:0]    bit_cnt;
    logic [DW-1:0] shreg, out_sh, rd_data;
    logic [AW-1:0] ptr;
    logic          blk_q, rw_q, m_ack, sda_pull_q;
    logic          busy, commit_en, has_data;
    logic [PAGE_W-1:0] commit_idx;
    logic          byte_in, hdr_match, buf_we, buf_clr, arm;

    smt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .ev(ev)
    );

    assign byte_in   = (bit_cnt == 4'd8);
    assign hdr_match = (shreg[7:4] == DEV_TYPE) && (shreg[3] == strap_hi_i)
                       && (shreg[2] == strap_lo_i) && !busy;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (ev.start) begin
            state_d = S_DEV;
        end else if (ev.stop) begin
            state_d = S_IDLE;
        end else if (ev.scl_fall) begin
            unique case (state_q)
                S_IDLE:      state_d = S_IDLE;
                S_DEV:       if (byte_in) state_d = hdr_match ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK:   state_d = rw_q ? S_RDATA : S_WORD;
                S_WORD:      if (byte_in) state_d = S_WORD_ACK;
                S_WORD_ACK:  state_d = S_WDATA;
                S_WDATA:     if (byte_in) state_d = S_WDATA_ACK;
                S_WDATA_ACK: state_d = S_WDATA;
                S_RDATA:     if (byte_in) state_d = S_RACK;
                S_RACK:      state_d = m_ack ? S_RDATA : S_IDLE;
                default:     state_d = S_IDLE;
            endcase
        end
    end

    // Datapath: shifter, bit counter, address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            out_sh  <= '1;
            ptr     <= '0;
            blk_q   <= 1'b0;
            rw_q    <= 1'b0;
            m_ack   <= 1'b0;
        end else if (ev.start || ev.stop) begin
            bit_cnt <= '0;
        end else begin
            if (ev.scl_rise) begin
                if (state_q inside {S_DEV, S_WORD, S_WDATA}) begin
                    shreg   <= {shreg[DW-2:0], ev.sda};
                    bit_cnt <= bit_cnt + 1'b1;
                end
                if (state_q == S_RDATA) bit_cnt <= bit_cnt + 1'b1;
                if (state_q == S_RACK)  m_ack   <= ~ev.sda;
            end
            if (ev.scl_fall) begin
                unique case (state_q)
                    S_DEV: if (byte_in) begin
                        rw_q    <= shreg[0];
                        blk_q   <= shreg[1];
                        bit_cnt <= '0;
                    end
                    S_DEV_ACK: if (rw_q) begin
                        out_sh <= {rd_data[DW-2:0], 1'b1};
                        ptr    <= ptr + 1'b1;
                    end
                    S_WORD: if (byte_in) begin
                        ptr     <= {blk_q, shreg};
                        bit_cnt <= '0;
                    end
                    S_WDATA: if (byte_in) begin
                        ptr     <= {ptr[AW-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
                        bit_cnt <= '0;
                    end
                    S_RDATA: begin
                        if (byte_in) bit_cnt <= '0;
                        else         out_sh  <= {out_sh[DW-2:0], 1'b1};
                    end
                    S_RACK: if (m_ack) begin
                        out_sh <= {rd_data[DW-2:0], 1'b1};
                        ptr    <= ptr + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Output: SDA pull-low, updated only after SCL falls
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull_q <= 1'b0;
        end else if (ev.start || ev.stop) begin
            sda_pull_q <= 1'b0;
        end else if (ev.scl_fall) begin
            unique case (state_q)
                S_DEV:            sda_pull_q <= byte_in && hdr_match;
                S_WORD, S_WDATA:  sda_pull_q <= byte_in;
                S_DEV_ACK:        sda_pull_q <= rw_q && !rd_data[DW-1];
                S_RDATA:          sda_pull_q <= !byte_in && !out_sh[DW-1];
                S_RACK:           sda_pull_q <= m_ack && !rd_data[DW-1];
                default:          sda_pull_q <= 1'b0;
            endcase
        end
    end

    assign sda_pull_o = sda_pull_q;

    // Page buffer and commit control
    assign buf_we  = ev.scl_fall && (state_q == S_WDATA) && byte_in;
    assign buf_clr = ev.start || ev.stop || (ev.scl_fall && (state_q == S_WORD) && byte_in);
    assign arm     = ev.stop && has_data && !wp_i && !busy;

    smt_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_W(PAGE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .go(arm), .busy(busy),
        .commit_en(commit_en), .commit_idx(commit_idx)
    );

    smt_store #(.PAGE_W(PAGE_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(ptr), .rd_data(rd_data),
        .buf_we(buf_we), .buf_idx(ptr[PAGE_W-1:0]), .buf_data(shreg),
        .buf_clr(buf_clr), .has_data(has_data),
        .arm(arm), .arm_page(ptr[AW-1:PAGE_W]),
        .commit_en(commit_en), .commit_idx(commit_idx)
    );

    assert_start_to_header_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev.start |=> (state_q == S_DEV));
    assert_stop_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ev.stop |=> (!sda_pull_q && state_q == S_IDLE));
    assert_pull_in_owned_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull_q |-> (state_q inside {S_DEV_ACK, S_WORD_ACK, S_WDATA_ACK, S_RDATA}));
    assert_nack_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DEV && ev.scl_fall && byte_in && busy) |=> !sda_pull_q);
    assert_page_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WDATA && ev.scl_fall && byte_in)
        |=> (ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W])));
    assert_wp_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.stop && wp_i && !busy) |=> !busy);
endmodule

// File: tb/sim_serial_mem_target.sv
module sim_serial_mem_target;
    localparam int BUSY = 400;
    localparam int H    = 8;

    typedef struct {
        logic [7:0] val;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_pull;
    wire  sda_line = sda_m & ~sda_pull;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t       exp_q[$];
    logic [7:0] got_q[$];
    logic [7:0] wbuf[8];

    always #4 clk = ~clk;

    serial_mem_target #(.PAGE_W(4), .BUSY_CYCLES(BUSY), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .strap_hi_i(1'b1), .strap_lo_i(1'b0), .wp_i(wp)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] hdr(input bit blk, input bit rd);
        return {4'b1010, 1'b1, 1'b0, blk, rd};
    endfunction

    task automatic expect_b(input logic [7:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: pops received bytes and compares them with the scoreboard.
    initial begin
        forever begin
            @(negedge clk);
            while (got_q.size() > 0) begin
                logic [7:0] g;
                exp_t e;
                g = got_q.pop_front();
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected byte", g, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(g === e.val, e.tag, g, e.val);
                end
            end
        end
    end

    task automatic bstart();
        sda_m = 1'b1; tick(2);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(2);
    endtask

    task automatic bstop();
        sda_m = 1'b0; tick(2);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H - 2);
            scl = 1'b1;   tick(H);
            scl = 1'b0;   tick(2);
        end
        sda_m = 1'b1; tick(H - 2);
        scl = 1'b1;   tick(H / 2);
        acked = !sda_line;
        tick(H / 2);
        scl = 1'b0;   tick(2);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H - 2);
            scl = 1'b1; tick(H / 2);
            b[i] = sda_line;
            tick(H / 2);
            scl = 1'b0; tick(2);
        end
        sda_m = give_ack ? 1'b0 : 1'b1;
        tick(H - 2);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic read_n(input int n, input string tag);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b);
            got_q.push_back(b);
        end
        tick(2);
        chk(sda_line === 1'b1, {tag, " R11 released after NACK"}, sda_line, 1);
    endtask

    task automatic wr(input bit blk, input logic [7:0] word, input int n, input string tag);
        bit a;
        bstart();
        send_byte(hdr(blk, 1'b0), a); chk(a, {tag, " R3 header ack"}, a, 1);
        send_byte(word, a);           chk(a, {tag, " word ack"}, a, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a);    chk(a, {tag, " data ack"}, a, 1);
        end
        bstop();
    endtask

    task automatic rd_random(input bit blk, input logic [7:0] word, input int n);
        bit a;
        bstart();
        send_byte(hdr(blk, 1'b0), a); chk(a, "R10 write header ack", a, 1);
        send_byte(word, a);           chk(a, "R10 word ack", a, 1);
        bstart();
        send_byte(hdr(blk, 1'b1), a); chk(a, "R10 read header ack", a, 1);
        read_n(n, "R10");
        bstop();
    endtask

    task automatic rd_current(input bit blk, input int n);
        bit a;
        bstart();
        send_byte(hdr(blk, 1'b1), a); chk(a, "R9 read header ack", a, 1);
        read_n(n, "R9");
        bstop();
    endtask

    task automatic probe(input logic [7:0] h, input bit want, input string tag);
        bit a;
        bstart();
        send_byte(h, a);
        chk(a == want, tag, a, want);
        bstop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired R2 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        bit a;
        tick(5);
        rst_n = 1'b1;
        tick(10);
        // R1: released line, erased array, counter at 0
        chk(sda_line === 1'b1, "R1 SDA released after reset", sda_line, 1);
        expect_b(8'hFF, "R1 erased byte at counter 0");
        rd_current(1'b0, 1);

        // R5 page write with wrap: 0x0C..0x0F then 0x00, 0x01
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wbuf[3] = 8'h44; wbuf[4] = 8'h55; wbuf[5] = 8'h66;
        wr(1'b0, 8'h0C, 6, "R5");
        probe(hdr(1'b0, 1'b0), 1'b0, "R7 header NACK while busy");
        tick(BUSY + 20);
        probe(hdr(1'b0, 1'b0), 1'b1, "R7 header ACK after busy");
        probe(hdr(1'b0, 1'b0), 1'b1, "R6 header-only stop starts no busy");

        // R10 and R11: random read then sequential
        expect_b(8'h11, "R10 byte 0x00C");
        expect_b(8'h22, "R11 byte 0x00D");
        expect_b(8'h33, "R11 byte 0x00E");
        expect_b(8'h44, "R11 byte 0x00F");
        rd_random(1'b0, 8'h0C, 4);
        expect_b(8'h55, "R5 wrapped byte 0x000");
        expect_b(8'h66, "R5 wrapped byte 0x001");
        rd_random(1'b0, 8'h00, 2);
        expect_b(8'h11, "R10 byte 0x00C again");
        rd_random(1'b0, 8'h0C, 1);
        // R9: counter now 0x00D; the block bit of a read header is ignored
        expect_b(8'h22, "R9 current read after random");
        rd_current(1'b1, 1);

        // R3: block bit selects the upper half
        wbuf[0] = 8'h5A;
        wr(1'b1, 8'h0C, 1, "R3");
        tick(BUSY + 20);
        expect_b(8'h5A, "R3 upper half byte 0x10C");
        rd_random(1'b1, 8'h0C, 1);
        expect_b(8'h11, "R3 lower half byte 0x00C kept");
        rd_random(1'b0, 8'h0C, 1);

        // R11 wrap across the array end, R5 wrap inside the last page
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        wr(1'b1, 8'hFF, 2, "R5");
        tick(BUSY + 20);
        expect_b(8'hC3, "R11 byte 0x1FF");
        expect_b(8'h55, "R11 rolled to 0x000");
        expect_b(8'h66, "R11 byte 0x001");
        rd_random(1'b1, 8'hFF, 3);
        expect_b(8'h3C, "R5 page wrap to 0x1F0");
        rd_random(1'b1, 8'hF0, 1);

        // R4: mismatching headers are ignored until the next start
        bstart();
        send_byte({4'b1010, 1'b1, 1'b1, 1'b0, 1'b0}, a);
        chk(!a, "R4 strap mismatch NACK", a, 0);
        send_byte(8'h0C, a);
        chk(!a, "R4 word ignored", a, 0);
        send_byte(8'h99, a);
        chk(!a, "R4 data ignored", a, 0);
        bstop();
        probe({4'b1011, 1'b1, 1'b0, 1'b0, 1'b0}, 1'b0, "R4 type mismatch NACK");
        probe(hdr(1'b0, 1'b0), 1'b1, "R4 no busy after ignored write");
        expect_b(8'h11, "R4 byte 0x00C unchanged");
        rd_random(1'b0, 8'h0C, 1);

        // R8: write protect
        wp = 1'b1;
        wbuf[0] = 8'h77;
        wr(1'b0, 8'h20, 1, "R8");
        probe(hdr(1'b0, 1'b0), 1'b1, "R8 no busy under protect");
        wp = 1'b0;
        expect_b(8'hFF, "R8 byte 0x020 unchanged");
        rd_random(1'b0, 8'h20, 1);

        tick(50);
        chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule